// File: doc/BRIEF.md
# LED Capacity Bar Driver

This block lights a five-segment LED bar that shows how much charge remains in a battery pack. Each segment stands for one fifth of a full-scale reference. A mode bit picks that reference: either the capacity learned from the last full discharge, or the fixed programmed full count. The segments are multiplexed in two banks at a reduced duty cycle. The first segment blinks to warn of a low battery. The bar is blanked completely when the final end-of-discharge flag is set.

Whether the bar is shown at all depends on a three-state request input. High disables the bar. Low, as from a held push-button, shows it and keeps it on for 4 seconds after release. With the input floating, charge activity or fast-discharge activity turns the bar on, and it stays on for 10 seconds after fast discharge ends. A test override can drive the segments directly. A 4-bit gauge value, giving the remaining fraction in sixteenths, is provided for register readback. All timing comes from the system clock through parameterised tick dividers.

Top module: `capbar_driver`

## Requirements
- R1: With reference F > 0 and available charge N, segment 1 lights when N > 0, and segment k (k = 2..5) lights when 5·N > (k−1)·F. The lit count therefore equals ceil(5·N/F), capped at 5. Segment k is `seg_n[k-1]`, and it is active low.
- R2: When `abs_mode` = 1 the reference F is `pfc`; when `abs_mode` = 0 it is `lmd`.
- R3: A frame has 10 slots of `SLOT_DIV` clocks each. Segments 1, 3 and 5 (bank A) may light only in slots 0–2, and segments 2 and 4 (bank B) only in slots 5–7. The two banks are never lit in the same cycle, and `com_on` is high for 6 of every 10 slots while the bar is shown.
- R4: Segment 1 blinks whenever `edv1` = 1 or 10·N < F. It is lit for `HALF_BLINK_SLOTS` slots and dark for the same number, while the other segments keep their R1 state.
- R5: When `edvf` = 1 and the override is off, no segment lights.
- R6: `req_mode` is encoded as 00 = floating, 01 = low (pressed), and 1x = high. High turns the bar off and clears both hold timers.
- R7: While `req_mode` = 01 the bar is shown. After the input leaves that state for floating, the bar stays shown for `PUSH_HOLD_S` seconds, counted in units of `SLOTS_PER_SEC` slots.
- R8: With `req_mode` = 00, the bar is shown while `chg_act` or `dsg_fast` is 1. It stays shown for `DSG_HOLD_S` seconds after `dsg_fast` falls, and goes dark within a few cycles after `chg_act` falls if nothing else holds it.
- R9: When `ovr_en` = 1, `ovr_seg[k-1]` drives segment k in place of the computed pattern. The bar is shown regardless of `req_mode` and `edvf`, and bank multiplexing still applies.
- R10: While the bar is not shown, `com_on` = 0 and all of `seg_n` are 1.
- R11: `gauge` = min(15, floor(16·N/F)). When F = 0, `gauge` = 0 and no segment lights.
- R12: During reset and until the first frame, `seg_n` = 11111, `com_on` = 0 and `gauge` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nac | input | W | Available charge count |
| lmd | input | W | Learned full capacity |
| pfc | input | W | Programmed full count |
| abs_mode | input | 1 | 1 selects `pfc` as the reference, 0 selects `lmd` |
| req_mode | input | 2 | Display request: 00 floating, 01 low, 1x high |
| chg_act | input | 1 | Charge activity in progress |
| dsg_fast | input | 1 | Fast-discharge activity in progress |
| edv1 | input | 1 | First end-of-discharge flag |
| edvf | input | 1 | Final end-of-discharge flag |
| ovr_en | input | 1 | Test override enable |
| ovr_seg | input | 5 | Override pattern; bit k-1 drives segment k |
| seg_n | output | 5 | Active-low segment drives |
| com_on | output | 1 | LED common enable |
| gauge | output | 4 | Remaining fraction in sixteenths |

## Verification
A slot or frame counter that goes off track shows up as a changed `com_on` count or as both banks lit together within one frame, which is 10·`SLOT_DIV` clocks. A wrong threshold product or a wrong reference choice changes the union of lit segments, or the `gauge` value, within three cycles of the input change. Blink and hold counters only reveal errors over their own spans: the lit-cycle count of segment 1 across one full blink cycle, and whether the bar is still shown just before each hold expires and dark just after.

// File: rtl/capbar_pkg.sv
package capbar_pkg;
  typedef enum logic [1:0] {
    REQ_FLOAT = 2'b00,
    REQ_LOW   = 2'b01,
    REQ_HIGH  = 2'b10,
    REQ_HIGH2 = 2'b11
  } req_e;

  localparam int          NSEG        = 5;
  localparam int          FRAME_SLOTS = 10;
  localparam logic [4:0]  BANK_A_MASK = 5'b10101;
  localparam logic [4:0]  BANK_B_MASK = 5'b01010;
endpackage

// File: rtl/capbar_timebase.sv
module capbar_timebase #(
  parameter int SLOT_DIV         = 78125,
  parameter int HALF_BLINK_SLOTS = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_tick,
  output logic bank_a_win,
  output logic bank_b_win,
  output logic blink_on
);
  import capbar_pkg::*;
  localparam int DIV_W = ($clog2(SLOT_DIV) > 0) ? $clog2(SLOT_DIV) : 1;
  localparam int BL_W  = ($clog2(HALF_BLINK_SLOTS) > 0) ? $clog2(HALF_BLINK_SLOTS) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic [3:0]       slot_idx;
  logic [BL_W-1:0]  blink_cnt;

  assign slot_tick  = (div_cnt == DIV_W'(SLOT_DIV - 1));
  assign bank_a_win = (slot_idx < 4'd3);
  assign bank_b_win = (slot_idx >= 4'd5) && (slot_idx < 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      slot_idx  <= '0;
      blink_cnt <= '0;
      blink_on  <= 1'b1;
    end else begin
      div_cnt <= slot_tick ? '0 : div_cnt + 1'b1;
      if (slot_tick) begin
        slot_idx <= (slot_idx == 4'(FRAME_SLOTS - 1)) ? '0 : slot_idx + 1'b1;
        if (blink_cnt == BL_W'(HALF_BLINK_SLOTS - 1)) begin
          blink_cnt <= '0;
          blink_on  <= ~blink_on;
        end else begin
          blink_cnt <= blink_cnt + 1'b1;
        end
      end
    end
  end

  // R3: the slot index never leaves the frame
  a_r3_slot_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx < 4'(FRAME_SLOTS));
  // R3: the slot index moves only on a slot tick
  a_r3_slot_steps_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(slot_idx));
endmodule

// File: rtl/capbar_level.sv
module capbar_level #(
  parameter int W = 16
) (
  input  logic [W-1:0] nac,
  input  logic [W-1:0] lmd,
  input  logic [W-1:0] pfc,
  input  logic         abs_mode,
  output logic [W-1:0] full_ref,
  output logic [4:0]   lit,
  output logic         low,
  output logic [3:0]   gauge
);
  localparam int XW = W + 5;

  function automatic logic [4:0] bar_mask(input logic [W-1:0] n, input logic [W-1:0] r);
    logic [XW-1:0] n5;
    logic [4:0]    m;
    n5 = XW'(n) * XW'(5);
    m  = '0;
    if (r != '0) begin
      m[0] = (n != '0);
      for (int k = 1; k < 5; k++)
        m[k] = (n5 > XW'(r) * XW'(k));
    end
    return m;
  endfunction

  function automatic logic below_tenth(input logic [W-1:0] n, input logic [W-1:0] r);
    return (XW'(n) * XW'(10)) < XW'(r);
  endfunction

  function automatic logic [3:0] sixteenths(input logic [W-1:0] n, input logic [W-1:0] r);
    logic [XW-1:0] n16;
    logic [3:0]    g;
    n16 = XW'(n) << 4;
    g   = '0;
    if (r != '0)
      for (int j = 1; j < 16; j++)
        if (n16 >= XW'(r) * XW'(j)) g = 4'(j);
    return g;
  endfunction

  assign full_ref = abs_mode ? pfc : lmd;
  assign lit      = bar_mask(nac, full_ref);
  assign low      = below_tenth(nac, full_ref);
  assign gauge    = sixteenths(nac, full_ref);
endmodule

// File: rtl/capbar_activity.sv
module capbar_activity #(
  parameter int PUSH_SLOTS = 12800,
  parameter int DSG_SLOTS  = 32000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_tick,
  input  logic [1:0] req_mode,
  input  logic       chg_act,
  input  logic       dsg_fast,
  output logic       active,
  output logic       push_hold_live,
  output logic       dsg_hold_live
);
  import capbar_pkg::*;
  localparam int PW = $clog2(PUSH_SLOTS + 1);
  localparam int DW = $clog2(DSG_SLOTS + 1);

  req_e        req;
  logic        blocked;
  logic [PW-1:0] push_cnt;
  logic [DW-1:0] dsg_cnt;

  assign req            = req_e'(req_mode);
  assign blocked        = req_mode[1];
  assign push_hold_live = (push_cnt != '0);
  assign dsg_hold_live  = (dsg_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_cnt <= '0;
      dsg_cnt  <= '0;
    end else if (blocked) begin
      push_cnt <= '0;
      dsg_cnt  <= '0;
    end else begin
      if (req == REQ_LOW)                push_cnt <= PW'(PUSH_SLOTS);
      else if (slot_tick && push_hold_live) push_cnt <= push_cnt - 1'b1;
      if (dsg_fast)                      dsg_cnt <= DW'(DSG_SLOTS);
      else if (slot_tick && dsg_hold_live) dsg_cnt <= dsg_cnt - 1'b1;
    end
  end

  assign active = !blocked &&
                  ((req == REQ_LOW) || push_hold_live ||
                   ((req == REQ_FLOAT) && (chg_act || dsg_fast || dsg_hold_live)));

  // R7: a pressed request arms the release hold
  a_r7_push_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (req == REQ_LOW) |=> push_hold_live);
  // R6: a high request leaves no hold running
  a_r6_high_clears_holds: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (!push_hold_live && !dsg_hold_live));
  // R8: fast discharge arms its hold
  a_r8_dsg_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (dsg_fast && !blocked) |=> dsg_hold_live);
endmodule

// File: rtl/capbar_driver.sv
module capbar_driver #(
  parameter int W                = 16,
  parameter int SLOT_DIV         = 78125,
  parameter int SLOTS_PER_SEC    = 3200,
  parameter int HALF_BLINK_SLOTS = 400,
  parameter int PUSH_HOLD_S      = 4,
  parameter int DSG_HOLD_S       = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nac,
  input  logic [W-1:0] lmd,
  input  logic [W-1:0] pfc,
  input  logic         abs_mode,
  input  logic [1:0]   req_mode,
  input  logic         chg_act,
  input  logic         dsg_fast,
  input  logic         edv1,
  input  logic         edvf,
  input  logic         ovr_en,
  input  logic [4:0]   ovr_seg,
  output logic [4:0]   seg_n,
  output logic         com_on,
  output logic [3:0]   gauge
);
  import capbar_pkg::*;
  localparam int PUSH_SLOTS = PUSH_HOLD_S * SLOTS_PER_SEC;
  localparam int DSG_SLOTS  = DSG_HOLD_S * SLOTS_PER_SEC;

  logic         slot_tick, bank_a_win, bank_b_win, blink_on;
  logic         active, push_hold_live, dsg_hold_live;
  logic [W-1:0] full_ref;
  logic [4:0]   lit, pattern, window;
  logic         low, show;
  logic [3:0]   gauge_c;

  capbar_timebase #(.SLOT_DIV(SLOT_DIV), .HALF_BLINK_SLOTS(HALF_BLINK_SLOTS)) u_time (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
    .bank_a_win(bank_a_win), .bank_b_win(bank_b_win), .blink_on(blink_on));

  capbar_level #(.W(W)) u_level (
    .nac(nac), .lmd(lmd), .pfc(pfc), .abs_mode(abs_mode),
    .full_ref(full_ref), .lit(lit), .low(low), .gauge(gauge_c));

  capbar_activity #(.PUSH_SLOTS(PUSH_SLOTS), .DSG_SLOTS(DSG_SLOTS)) u_act (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .req_mode(req_mode),
    .chg_act(chg_act), .dsg_fast(dsg_fast), .active(active),
    .push_hold_live(push_hold_live), .dsg_hold_live(dsg_hold_live));

  always_comb begin
    if (ovr_en) begin
      pattern = ovr_seg;
      show    = 1'b1;
    end else if (edvf) begin
      pattern = '0;
      show    = active;
    end else begin
      pattern = lit;
      if (edv1 || low) pattern[0] = blink_on;
      show = active;
    end
    if (bank_a_win)      window = BANK_A_MASK;
    else if (bank_b_win) window = BANK_B_MASK;
    else                 window = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n  <= '1;
      com_on <= 1'b0;
      gauge  <= '0;
    end else begin
      seg_n  <= ~(pattern & window & {NSEG{show}});
      com_on <= show && (bank_a_win || bank_b_win);
      gauge  <= gauge_c;
    end
  end

  // R10: a segment never lights without the common
  a_r10_dark_without_common: assert property (@(posedge clk) disable iff (!rst_n)
    !com_on |-> (&seg_n));
  // R3: the two banks never light together
  a_r3_banks_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(~seg_n & BANK_A_MASK)) && (|(~seg_n & BANK_B_MASK))));
  // R5: final end-of-discharge blanks every segment
  a_r5_final_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (edvf && !ovr_en) |=> (&seg_n));
  // R6: a high request darkens the common
  a_r6_high_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode[1] && !ovr_en) |=> !com_on);
  // R9: override drives bank A segments directly
  a_r9_override_bank_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && bank_a_win) |=> (seg_n == ~($past(ovr_seg) & BANK_A_MASK)));
  // R11: charge at or above the reference reads as full
  a_r11_gauge_top: assert property (@(posedge clk) disable iff (!rst_n)
    ((full_ref != '0) && (nac >= full_ref)) |=> (gauge == 4'hF));
endmodule

// File: tb/capbar_driver_test.sv
module capbar_driver_test;
  localparam int W     = 16;
  localparam int SDIV  = 2;
  localparam int SPS   = 40;
  localparam int HBL   = 20;
  localparam int FRAME = 10 * SDIV;
  localparam int SEC   = SPS * SDIV;
  localparam int BLINK = 2 * HBL * SDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] nac = '0, lmd = '0, pfc = '0;
  logic abs_mode = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic chg_act = 1'b0, dsg_fast = 1'b0, edv1 = 1'b0, edvf = 1'b0, ovr_en = 1'b0;
  logic [4:0] ovr_seg = '0;
  logic [4:0] seg_n;
  logic com_on;
  logic [3:0] gauge;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  capbar_driver #(.W(W), .SLOT_DIV(SDIV), .SLOTS_PER_SEC(SPS), .HALF_BLINK_SLOTS(HBL),
                  .PUSH_HOLD_S(4), .DSG_HOLD_S(10)) uut (
    .clk(clk), .rst_n(rst_n), .nac(nac), .lmd(lmd), .pfc(pfc), .abs_mode(abs_mode),
    .req_mode(req_mode), .chg_act(chg_act), .dsg_fast(dsg_fast), .edv1(edv1), .edvf(edvf),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .seg_n(seg_n), .com_on(com_on), .gauge(gauge));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_mask(input int n, input int r);
    int c;
    if (r == 0) return 5'b0;
    c = (5 * n + r - 1) / r;
    if (c > 5) c = 5;
    return 5'((1 << c) - 1);
  endfunction

  function automatic int exp_gauge(input int n, input int r);
    int g;
    if (r == 0) return 0;
    g = (16 * n) / r;
    return (g > 15) ? 15 : g;
  endfunction

  task automatic observe(input int ncyc, output logic [4:0] uni, output int coms,
                         output int s1, output int both);
    uni = '0; coms = 0; s1 = 0; both = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      uni |= ~seg_n;
      if (com_on) coms++;
      if (!seg_n[0]) s1++;
      if ((|(~seg_n & 5'b10101)) && (|(~seg_n & 5'b01010))) both++;
    end
  endtask

  task automatic settle;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check(seg_n == 5'h1F, "R12 seg_n", seg_n, 31);
    check(com_on == 1'b0, "R12 com_on", com_on, 0);
    check(gauge == 4'h0, "R12 gauge", gauge, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(com_on == 1'b0 && seg_n == 5'h1F, "R12 after release", com_on, 0);
  endtask

  task automatic t_levels;
    logic [4:0] u; int c, s, b;
    int vals[5] = '{1000, 400, 399, 150, 1200};
    req_mode = 2'b01; abs_mode = 1'b0; lmd = 16'd1000; pfc = 16'd2000;
    foreach (vals[i]) begin
      @(negedge clk); nac = 16'(vals[i]); settle;
      observe(BLINK, u, c, s, b);
      check(u == exp_mask(vals[i], 1000), "R1 lit set", u, exp_mask(vals[i], 1000));
      check(s == 24, "R1 seg1 steady", s, 24);
    end
  endtask

  task automatic t_mode;
    logic [4:0] u; int c, s, b;
    @(negedge clk); nac = 16'd600; lmd = 16'd600; pfc = 16'd1000; abs_mode = 1'b1; settle;
    observe(FRAME, u, c, s, b);
    check(u == exp_mask(600, 1000), "R2 absolute uses pfc", u, exp_mask(600, 1000));
    @(negedge clk); abs_mode = 1'b0; settle;
    observe(FRAME, u, c, s, b);
    check(u == exp_mask(600, 600), "R2 relative uses lmd", u, exp_mask(600, 600));
  endtask

  task automatic t_duty;
    logic [4:0] u; int c, s, b;
    @(negedge clk); nac = 16'd1000; lmd = 16'd1000; settle;
    observe(4 * FRAME, u, c, s, b);
    check(c == 4 * 6 * SDIV, "R3 common duty", c, 4 * 6 * SDIV);
    check(b == 0, "R3 banks overlap", b, 0);
  endtask

  task automatic t_blink;
    logic [4:0] u; int c, s, b;
    @(negedge clk); nac = 16'd50; settle;
    observe(BLINK, u, c, s, b);
    check(s == 12, "R4 low blink", s, 12);
    @(negedge clk); nac = 16'd100; settle;
    observe(BLINK, u, c, s, b);
    check(s == 24, "R4 tenth boundary steady", s, 24);
    @(negedge clk); nac = 16'd1000; edv1 = 1'b1; settle;
    observe(BLINK, u, c, s, b);
    check(s == 12, "R4 edv1 blink", s, 12);
    check(u == 5'b11111, "R4 others kept", u, 31);
    @(negedge clk); edv1 = 1'b0;
  endtask

  task automatic t_edvf;
    logic [4:0] u; int c, s, b;
    @(negedge clk); edvf = 1'b1; settle;
    observe(2 * FRAME, u, c, s, b);
    check(u == 5'b0, "R5 final blank", u, 0);
    @(negedge clk); edvf = 1'b0;
  endtask

  task automatic t_high;
    logic [4:0] u; int c, s, b;
    @(negedge clk); req_mode = 2'b10; chg_act = 1'b1; settle;
    observe(2 * FRAME, u, c, s, b);
    check(c == 0, "R6 high disables", c, 0);
    @(negedge clk); chg_act = 1'b0;
  endtask

  task automatic t_push;
    logic [4:0] u; int c, s, b;
    @(negedge clk); req_mode = 2'b01; settle;
    observe(FRAME, u, c, s, b);
    check(c == 12, "R7 pressed shown", c, 12);
    @(negedge clk); req_mode = 2'b00;
    repeat (3 * SEC) @(negedge clk);
    observe(FRAME, u, c, s, b);
    check(c == 12, "R7 held at 3 s", c, 12);
    repeat (SEC + SEC / 2 - FRAME) @(negedge clk);
    observe(FRAME, u, c, s, b);
    check(c == 0 && u == 5'b0, "R7 dark after 4 s", c, 0);
  endtask

  task automatic t_float;
    logic [4:0] u; int c, s, b;
    @(negedge clk); req_mode = 2'b00; settle;
    observe(FRAME, u, c, s, b);
    check(c == 0 && u == 5'b0, "R10 idle dark", c, 0);
    @(negedge clk); chg_act = 1'b1; settle;
    observe(FRAME, u, c, s, b);
    check(c == 12, "R8 charge shown", c, 12);
    @(negedge clk); chg_act = 1'b0; settle;
    observe(FRAME, u, c, s, b);
    check(c == 0, "R8 charge ends dark", c, 0);
    @(negedge clk); dsg_fast = 1'b1; settle;
    @(negedge clk); dsg_fast = 1'b0;
    repeat (9 * SEC) @(negedge clk);
    observe(FRAME, u, c, s, b);
    check(c == 12, "R8 discharge hold at 9 s", c, 12);
    repeat (2 * SEC - FRAME) @(negedge clk);
    observe(FRAME, u, c, s, b);
    check(c == 0, "R8 dark after 10 s", c, 0);
  endtask

  task automatic t_override;
    logic [4:0] u; int c, s, b;
    @(negedge clk); req_mode = 2'b10; ovr_en = 1'b1; ovr_seg = 5'b10110; settle;
    observe(FRAME, u, c, s, b);
    check(u == 5'b10110, "R9 override pattern", u, 22);
    check(b == 0, "R9 override still banked", b, 0);
    @(negedge clk); ovr_seg = 5'b01001; edvf = 1'b1; settle;
    observe(FRAME, u, c, s, b);
    check(u == 5'b01001, "R9 override beats edvf", u, 9);
    @(negedge clk); ovr_en = 1'b0; edvf = 1'b0; settle;
    observe(FRAME, u, c, s, b);
    check(c == 0 && u == 5'b0, "R10 dark when not shown", c, 0);
  endtask

  task automatic t_gauge;
    logic [4:0] u; int c, s, b;
    int ns[6] = '{1000, 500, 999, 62, 63, 0};
    abs_mode = 1'b0; lmd = 16'd1000;
    foreach (ns[i]) begin
      @(negedge clk); nac = 16'(ns[i]); settle;
      check(gauge == 4'(exp_gauge(ns[i], 1000)), "R11 gauge", gauge, exp_gauge(ns[i], 1000));
    end
    @(negedge clk); nac = 16'd500; lmd = 16'd0; req_mode = 2'b01; settle;
    check(gauge == 4'd0, "R11 zero reference gauge", gauge, 0);
    observe(FRAME, u, c, s, b);
    check(u == 5'b0, "R11 zero reference dark", u, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_levels;
    t_mode;
    t_duty;
    t_blink;
    t_edvf;
    t_high;
    t_push;
    t_float;
    t_override;
    t_gauge;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule